// File: doc/BRIEF.md
# Dual-Copy Integer Physical Register File

This block holds the integer physical registers of an out-of-order core as two full replicas, one per execution cluster. Each cluster reads its own replica through four combinational read ports: two for its integer ALU and two for its address-generation unit. It writes through two local write ports. A local write updates the cluster's own replica at the clock edge. The same write is carried across and written into the other replica one edge later. A read in the writing cluster in the same cycle as the write gets the new value through a bypass. Reads in the other cluster get the old value until the delayed write lands.

Each replica has 80 entries of 64 bits, addressed by a 7-bit physical tag:
- Tags 0 to 31 are the architectural registers.
- Tags 32 to 71 are the rename registers.
- Tags 72 to 79 form a shadow bank for privileged code.

Tag 31 always reads zero and cannot be written. While the privileged-mode input is high, tags 4 to 7 and 20 to 23 are redirected to the shadow bank. Each cluster exports a mask of the entries that still have a write in flight from the other cluster. An outside scheduler uses this mask to avoid reading a replica before it has caught up.

Top module: `rf_cluster_dup`

## Requirements
- R1: While reset is asserted, and after it is released, every read port in both clusters returns zero for every legal tag, both pending masks are zero and the error flag is low.
- R2: Tag 31 reads as zero in both clusters. A write to tag 31 is discarded: it sets no pending bit and is not bypassed.
- R3: A local write with a legal tag is returned at once by same-cycle reads of that tag in the same cluster, through the bypass. After the edge it is held in that cluster's replica.
- R4: A local write lands in the other cluster's replica at the second clock edge after it is presented. Reads in the other cluster between the two edges return the previous value.
- R5: Pending mask bit k of a cluster is high exactly during the cycle in which a write from the other cluster to storage entry k is in flight. At all other times it is low.
- R6: When writes to the same entry of one replica meet at one edge, the priority order is local port 0, then local port 1, then delayed remote port 0, then delayed remote port 1. The bypass gives local port 0 priority over local port 1.
- R7: While priv_mode is high, tags 4..7 address storage entries 72..75 and tags 20..23 address entries 76..79. While priv_mode is low, those tags address their own entries. Tags 72..79 always address the shadow entries directly. A delayed write keeps the mapping in force when it was issued.
- R8: tag_err is high in any cycle in which a read tag, or the tag of an enabled write, is 80 or above. Such a read returns zero, and such a write is discarded and sets no pending bit.
- R9: Once no cross-cluster writes are pending, the two replicas return identical values for every tag, provided no two clusters wrote the same entry in overlapping cycles.
- R10: The four read ports of a cluster are independent. Each returns the entry of its own tag in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously to clk |
| priv_mode | input | 1 | Shadow-bank redirection enable |
| c0_wr_en | input | 2 | Cluster 0 write enables, one per port |
| c0_wr_tag | input | 2x7 | Cluster 0 write tags |
| c0_wr_data | input | 2x64 | Cluster 0 write data |
| c0_rd_tag | input | 4x7 | Cluster 0 read tags |
| c0_rd_data | output | 4x64 | Cluster 0 read data |
| c0_rmt_pend | output | 80 | Entries of replica 0 still awaiting a write from cluster 1 |
| c1_wr_en | input | 2 | Cluster 1 write enables |
| c1_wr_tag | input | 2x7 | Cluster 1 write tags |
| c1_wr_data | input | 2x64 | Cluster 1 write data |
| c1_rd_tag | input | 4x7 | Cluster 1 read tags |
| c1_rd_data | output | 4x64 | Cluster 1 read data |
| c1_rmt_pend | output | 80 | Entries of replica 1 still awaiting a write from cluster 0 |
| tag_err | output | 1 | A read tag or an enabled write tag is out of range |

## Verification
Every tag is written from each cluster in turn, in pairs on both ports. The writing cluster, the other cluster and the other cluster's pending mask are sampled at three points: before the first edge, between the edges, and after the second edge. This separates a missing bypass, a missing or wrong-cycle delay, and a stale pending bit. A full read-back through all four ports of both clusters then exposes any difference between the replicas or between ports. Directed patterns cover the remaining cases:
- colliding writes to one tag at one edge, which tell the port priority apart;
- privileged and unprivileged reads of the redirected tags, which tell whether the shadow mapping is applied;
- writes to tag 31 and to out-of-range tags, which show whether discarded writes reach storage or the pending masks.

// File: rtl/rfc_pkg.sv
package rfc_pkg;
  localparam int TAG_W   = 7;
  localparam int NUM_ENT = 80;
  localparam logic [TAG_W-1:0] ENT_LIM  = TAG_W'(NUM_ENT);
  localparam logic [TAG_W-1:0] ZERO_TAG = TAG_W'(31);
  localparam logic [TAG_W-1:0] SH_BASE  = TAG_W'(72);
  localparam logic [TAG_W-1:0] SH_GRP   = TAG_W'(4);
  localparam logic [TAG_W-1:0] SH_LO    = TAG_W'(4);
  localparam logic [TAG_W-1:0] SH_HI    = TAG_W'(20);

  // Redirect the two architectural groups to the shadow bank in privileged mode.
  function automatic logic [TAG_W-1:0] map_tag(input logic [TAG_W-1:0] t, input logic priv);
    logic [TAG_W-1:0] m;
    m = t;
    if (priv) begin
      if (t >= SH_LO && t < SH_LO + SH_GRP)
        m = SH_BASE + (t - SH_LO);
      else if (t >= SH_HI && t < SH_HI + SH_GRP)
        m = SH_BASE + SH_GRP + (t - SH_HI);
    end
    return m;
  endfunction
endpackage

// File: rtl/rfc_xfer.sv
module rfc_xfer
  import rfc_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int NWR    = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NWR-1:0]                 src_we,
  input  logic [NWR-1:0][TAG_W-1:0]      src_tag,
  input  logic [NWR-1:0][DATA_W-1:0]     src_data,
  output logic [NWR-1:0]                 dly_we,
  output logic [NWR-1:0][TAG_W-1:0]      dly_tag,
  output logic [NWR-1:0][DATA_W-1:0]     dly_data,
  output logic [NUM_ENT-1:0]             pend
);
  logic [NWR-1:0] vld_q, vld_d;

  always_comb begin
    vld_d = src_we;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  for (genvar p = 0; p < NWR; p++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dly_tag[p]  <= '0;
        dly_data[p] <= '0;
      end else if (src_we[p]) begin
        dly_tag[p]  <= src_tag[p];
        dly_data[p] <= src_data[p];
      end
    end

    assert_launch_R4: assert property (@(posedge clk) disable iff (!rst_n)
      src_we[p] |=> (dly_we[p] && dly_tag[p] == $past(src_tag[p])));
  end

  assign dly_we = vld_q;

  always_comb begin
    pend = '0;
    for (int p = 0; p < NWR; p++)
      if (vld_q[p]) pend[dly_tag[p]] = 1'b1;
  end

  assert_pend_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (src_we == '0) |=> (pend == '0));
endmodule

// File: rtl/rfc_copy.sv
module rfc_copy
  import rfc_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int NWR    = 2,
  parameter int NRD    = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NWR-1:0]                 loc_we,
  input  logic [NWR-1:0][TAG_W-1:0]      loc_tag,
  input  logic [NWR-1:0][DATA_W-1:0]     loc_data,
  input  logic [NWR-1:0]                 rmt_we,
  input  logic [NWR-1:0][TAG_W-1:0]      rmt_tag,
  input  logic [NWR-1:0][DATA_W-1:0]     rmt_data,
  input  logic [NRD-1:0][TAG_W-1:0]      rd_tag,
  output logic [NRD-1:0][DATA_W-1:0]     rd_data
);
  logic [DATA_W-1:0] mem [NUM_ENT];

  for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
    logic [DATA_W-1:0] nxt;
    logic              en;

    // Lowest priority applied first so higher-priority sources overwrite.
    always_comb begin
      nxt = mem[i];
      en  = 1'b0;
      for (int p = NWR - 1; p >= 0; p--)
        if (rmt_we[p] && rmt_tag[p] == TAG_W'(i)) begin
          nxt = rmt_data[p];
          en  = 1'b1;
        end
      for (int p = NWR - 1; p >= 0; p--)
        if (loc_we[p] && loc_tag[p] == TAG_W'(i)) begin
          nxt = loc_data[p];
          en  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  mem[i] <= '0;
      else if (en) mem[i] <= nxt;
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    always_comb begin
      if (rd_tag[r] >= ENT_LIM || rd_tag[r] == ZERO_TAG) begin
        rd_data[r] = '0;
      end else begin
        rd_data[r] = mem[rd_tag[r]];
        for (int p = NWR - 1; p >= 0; p--)
          if (loc_we[p] && loc_tag[p] == rd_tag[r]) rd_data[r] = loc_data[p];
      end
    end
  end

  assert_zero_untouched_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem[ZERO_TAG] == '0);

  if (NWR >= 2) begin : g_prio_chk
    assert_local_prio_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (loc_we[0] && loc_we[1] && loc_tag[0] == loc_tag[1])
        |=> mem[$past(loc_tag[0])] == $past(loc_data[0]));

    assert_remote_land_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rmt_we[0] && !(loc_we[0] && loc_tag[0] == rmt_tag[0])
                 && !(loc_we[1] && loc_tag[1] == rmt_tag[0]))
        |=> mem[$past(rmt_tag[0])] == $past(rmt_data[0]));
  end
endmodule

// File: rtl/rf_cluster_dup.sv
module rf_cluster_dup
  import rfc_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int NWR    = 2,
  parameter int NRD    = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           priv_mode,
  input  logic [NWR-1:0]                 c0_wr_en,
  input  logic [NWR-1:0][TAG_W-1:0]      c0_wr_tag,
  input  logic [NWR-1:0][DATA_W-1:0]     c0_wr_data,
  input  logic [NRD-1:0][TAG_W-1:0]      c0_rd_tag,
  output logic [NRD-1:0][DATA_W-1:0]     c0_rd_data,
  output logic [NUM_ENT-1:0]             c0_rmt_pend,
  input  logic [NWR-1:0]                 c1_wr_en,
  input  logic [NWR-1:0][TAG_W-1:0]      c1_wr_tag,
  input  logic [NWR-1:0][DATA_W-1:0]     c1_wr_data,
  input  logic [NRD-1:0][TAG_W-1:0]      c1_rd_tag,
  output logic [NRD-1:0][DATA_W-1:0]     c1_rd_data,
  output logic [NUM_ENT-1:0]             c1_rmt_pend,
  output logic                           tag_err
);
  localparam int NCL = 2;

  logic [NWR-1:0]              raw_we   [NCL];
  logic [NWR-1:0][TAG_W-1:0]   raw_wtag [NCL];
  logic [NWR-1:0][DATA_W-1:0]  wdata    [NCL];
  logic [NRD-1:0][TAG_W-1:0]   raw_rtag [NCL];
  logic [NRD-1:0][DATA_W-1:0]  rdata    [NCL];
  logic [NWR-1:0]              q_we     [NCL];
  logic [NWR-1:0][TAG_W-1:0]   m_wtag   [NCL];
  logic [NRD-1:0][TAG_W-1:0]   m_rtag   [NCL];
  logic [NWR-1:0]              x_we     [NCL];
  logic [NWR-1:0][TAG_W-1:0]   x_tag    [NCL];
  logic [NWR-1:0][DATA_W-1:0]  x_data   [NCL];
  logic [NUM_ENT-1:0]          x_pend   [NCL];

  assign raw_we[0]   = c0_wr_en;
  assign raw_we[1]   = c1_wr_en;
  assign raw_wtag[0] = c0_wr_tag;
  assign raw_wtag[1] = c1_wr_tag;
  assign wdata[0]    = c0_wr_data;
  assign wdata[1]    = c1_wr_data;
  assign raw_rtag[0] = c0_rd_tag;
  assign raw_rtag[1] = c1_rd_tag;
  assign c0_rd_data  = rdata[0];
  assign c1_rd_data  = rdata[1];
  // A cluster's pending mask lists writes launched by the other cluster.
  assign c0_rmt_pend = x_pend[1];
  assign c1_rmt_pend = x_pend[0];

  for (genvar c = 0; c < NCL; c++) begin : g_cl
    always_comb begin
      for (int p = 0; p < NWR; p++) begin
        m_wtag[c][p] = map_tag(raw_wtag[c][p], priv_mode);
        q_we[c][p]   = raw_we[c][p] && raw_wtag[c][p] < ENT_LIM
                       && raw_wtag[c][p] != ZERO_TAG;
      end
      for (int r = 0; r < NRD; r++)
        m_rtag[c][r] = map_tag(raw_rtag[c][r], priv_mode);
    end

    rfc_xfer #(.DATA_W(DATA_W), .NWR(NWR)) xfer_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_we   (q_we[c]),
      .src_tag  (m_wtag[c]),
      .src_data (wdata[c]),
      .dly_we   (x_we[c]),
      .dly_tag  (x_tag[c]),
      .dly_data (x_data[c]),
      .pend     (x_pend[c])
    );

    rfc_copy #(.DATA_W(DATA_W), .NWR(NWR), .NRD(NRD)) copy_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .loc_we   (q_we[c]),
      .loc_tag  (m_wtag[c]),
      .loc_data (wdata[c]),
      .rmt_we   (x_we[NCL-1-c]),
      .rmt_tag  (x_tag[NCL-1-c]),
      .rmt_data (x_data[NCL-1-c]),
      .rd_tag   (m_rtag[c]),
      .rd_data  (rdata[c])
    );
  end

  always_comb begin
    tag_err = 1'b0;
    for (int c = 0; c < NCL; c++) begin
      for (int p = 0; p < NWR; p++)
        if (raw_we[c][p] && raw_wtag[c][p] >= ENT_LIM) tag_err = 1'b1;
      for (int r = 0; r < NRD; r++)
        if (raw_rtag[c][r] >= ENT_LIM) tag_err = 1'b1;
    end
  end

  assert_zero_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (c1_rd_tag[0] == ZERO_TAG) |-> (c1_rd_data[0] == '0));

  assert_bad_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (c0_rd_tag[0] >= ENT_LIM) |-> (tag_err && c0_rd_data[0] == '0));
endmodule

// File: tb/rf_cluster_dup_tb.sv
module rf_cluster_dup_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic priv;
  logic [1:0]             we    [2];
  logic [1:0][6:0]        wtag  [2];
  logic [1:0][63:0]       wdat  [2];
  logic [3:0][6:0]        rtag  [2];
  logic [3:0][63:0]       rdat  [2];
  logic [79:0]            rpend [2];
  logic                   tag_err;
  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rf_cluster_dup dut_i (
    .clk(clk), .rst_n(rst_n), .priv_mode(priv),
    .c0_wr_en(we[0]), .c0_wr_tag(wtag[0]), .c0_wr_data(wdat[0]),
    .c0_rd_tag(rtag[0]), .c0_rd_data(rdat[0]), .c0_rmt_pend(rpend[0]),
    .c1_wr_en(we[1]), .c1_wr_tag(wtag[1]), .c1_wr_data(wdat[1]),
    .c1_rd_tag(rtag[1]), .c1_rd_data(rdat[1]), .c1_rmt_pend(rpend[1]),
    .tag_err(tag_err)
  );

  function automatic logic [63:0] dv(int t, int s);
    return {32'(s * 4096 + t + 1), 32'(32'hFEED0000 | t)};
  endfunction

  function automatic logic [63:0] ev(int t, int s);
    return (t == 31) ? 64'h0 : dv(t, s);
  endfunction

  task automatic chk(string req, logic [79:0] act, logic [79:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    for (int c = 0; c < 2; c++) begin
      we[c] = '0; wtag[c] = '0; wdat[c] = '0; rtag[c] = '0;
    end
  endtask

  task automatic sweep(int s, int seed);
    int o;
    int t0, t1;
    logic [79:0] m;
    o = 1 - s;
    for (int i = 0; i < 40; i++) begin
      t0 = 2 * i; t1 = 2 * i + 1;
      m = '0;
      if (t0 != 31) m[t0] = 1'b1;
      if (t1 != 31) m[t1] = 1'b1;
      @(negedge clk);
      we[s] = 2'b11;
      wtag[s][0] = 7'(t0); wtag[s][1] = 7'(t1);
      wdat[s][0] = dv(t0, seed); wdat[s][1] = dv(t1, seed);
      rtag[s][0] = 7'(t0); rtag[s][1] = 7'(t1);
      rtag[o][0] = 7'(t0); rtag[o][1] = 7'(t1);
      #1;
      chk("R3 bypass p0", 80'(rdat[s][0]), 80'(ev(t0, seed)));
      chk("R3 bypass p1", 80'(rdat[s][1]), 80'(ev(t1, seed)));
      chk("R4 remote old", 80'(rdat[o][0]), 80'(seed == 1 ? 64'h0 : ev(t0, seed - 1)));
      @(negedge clk);
      we[s] = 2'b00;
      #1;
      chk("R3 local held", 80'(rdat[s][0]), 80'(ev(t0, seed)));
      chk("R4 remote still old", 80'(rdat[o][1]), 80'(seed == 1 ? 64'h0 : ev(t1, seed - 1)));
      chk("R5 pending set", rpend[o], m);
      chk("R5 own mask clear", rpend[s], 80'h0);
      @(negedge clk);
      #1;
      chk("R4 remote landed p0", 80'(rdat[o][0]), 80'(ev(t0, seed)));
      chk("R4 remote landed p1", 80'(rdat[o][1]), 80'(ev(t1, seed)));
      chk("R5 pending cleared", rpend[o], 80'h0);
    end
  endtask

  initial begin
    #(8 * 200000);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    done = 1;
  end

  initial begin
    priv = 1'b0;
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reads during reset
    for (int k = 0; k < 20; k++) begin
      for (int r = 0; r < 4; r++) begin rtag[0][r] = 7'(4 * k + r); rtag[1][r] = 7'(4 * k + r); end
      #1;
      for (int r = 0; r < 4; r++) begin
        chk("R1 reset read c0", 80'(rdat[0][r]), 80'h0);
        chk("R1 reset read c1", 80'(rdat[1][r]), 80'h0);
      end
      @(negedge clk);
    end
    rst_n = 1'b1;
    idle();
    @(negedge clk);
    #1;
    chk("R1 pend c0", rpend[0], 80'h0);
    chk("R1 pend c1", rpend[1], 80'h0);
    chk("R1 tag_err low", 80'(tag_err), 80'h0);
    chk("R1 read after release", 80'(rdat[1][0]), 80'h0);

    sweep(0, 1);
    sweep(1, 2);

    // R9/R10: full read-back, all ports, both replicas
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      for (int r = 0; r < 4; r++) begin rtag[0][r] = 7'(4 * k + r); rtag[1][r] = 7'(79 - 4 * k - r); end
      #1;
      for (int r = 0; r < 4; r++) begin
        chk("R10 port read c0", 80'(rdat[0][r]), 80'(ev(4 * k + r, 2)));
        chk("R9 replica match c1", 80'(rdat[1][r]), 80'(ev(79 - 4 * k - r, 2)));
      end
    end

    // R7: shadow bank
    idle();
    @(negedge clk);
    priv = 1'b1;
    we[0] = 2'b01; wtag[0][0] = 7'd4; wdat[0][0] = 64'h5A5A_0000_0000_0004;
    rtag[0][0] = 7'd4;
    #1;
    chk("R7 priv bypass", 80'(rdat[0][0]), 80'h5A5A_0000_0000_0004);
    @(negedge clk);
    we[0] = 2'b00;
    #1;
    chk("R7 shadow pending bit 72", rpend[1], 80'h1 << 72);
    @(negedge clk);
    priv = 1'b0;
    rtag[0][0] = 7'd4; rtag[0][1] = 7'd72; rtag[1][0] = 7'd72; rtag[1][1] = 7'd4;
    #1;
    chk("R7 arch 4 unchanged", 80'(rdat[0][0]), 80'(dv(4, 2)));
    chk("R7 direct 72", 80'(rdat[0][1]), 80'h5A5A_0000_0000_0004);
    chk("R7 remote 72", 80'(rdat[1][0]), 80'h5A5A_0000_0000_0004);
    chk("R7 remote arch 4", 80'(rdat[1][1]), 80'(dv(4, 2)));
    @(negedge clk);
    priv = 1'b1;
    rtag[1][0] = 7'd20; rtag[1][1] = 7'd23; rtag[1][2] = 7'd7; rtag[1][3] = 7'd31;
    #1;
    chk("R7 tag20->76", 80'(rdat[1][0]), 80'(dv(76, 2)));
    chk("R7 tag23->79", 80'(rdat[1][1]), 80'(dv(79, 2)));
    chk("R7 tag7->75", 80'(rdat[1][2]), 80'(dv(75, 2)));
    chk("R2 zero in priv", 80'(rdat[1][3]), 80'h0);

    // R6: priority
    idle();
    @(negedge clk);
    priv = 1'b0;
    we[0] = 2'b11; wtag[0][0] = 7'd11; wtag[0][1] = 7'd11;
    wdat[0][0] = 64'hAAAA; wdat[0][1] = 64'hBBBB; rtag[0][0] = 7'd11;
    #1;
    chk("R6 bypass p0 wins", 80'(rdat[0][0]), 80'hAAAA);
    @(negedge clk);
    we[0] = 2'b01; wtag[0][0] = 7'd10; wdat[0][0] = 64'h1111;
    #1;
    chk("R6 local p0 stored", 80'(rdat[0][0]), 80'hAAAA);
    @(negedge clk);
    we[0] = 2'b00;
    we[1] = 2'b01; wtag[1][0] = 7'd10; wdat[1][0] = 64'h2222; rtag[1][1] = 7'd11;
    #1;
    chk("R6 remote p0 over p1", 80'(rdat[1][1]), 80'hAAAA);
    @(negedge clk);
    we[1] = 2'b00; rtag[1][0] = 7'd10; rtag[0][0] = 7'd10;
    #1;
    chk("R6 local beats remote", 80'(rdat[1][0]), 80'h2222);
    chk("R4 c0 not yet updated", 80'(rdat[0][0]), 80'h1111);
    @(negedge clk);
    #1;
    chk("R9 c0 converged", 80'(rdat[0][0]), 80'h2222);
    chk("R9 c1 converged", 80'(rdat[1][0]), 80'h2222);

    // R8: illegal tags
    idle();
    @(negedge clk);
    rtag[0][2] = 7'd85;
    #1;
    chk("R8 err on read", 80'(tag_err), 80'h1);
    chk("R8 illegal read zero", 80'(rdat[0][2]), 80'h0);
    @(negedge clk);
    rtag[0][2] = 7'd0;
    we[1] = 2'b10; wtag[1][1] = 7'd90; wdat[1][1] = 64'hDEAD;
    #1;
    chk("R8 err on write", 80'(tag_err), 80'h1);
    @(negedge clk);
    we[1] = 2'b00;
    #1;
    chk("R8 no pending", rpend[0], 80'h0);
    chk("R8 err clear", 80'(tag_err), 80'h0);

    // R2: writes to tag 31
    @(negedge clk);
    we[0] = 2'b01; wtag[0][0] = 7'd31; wdat[0][0] = 64'hFFFF; rtag[0][0] = 7'd31;
    #1;
    chk("R2 no bypass of 31", 80'(rdat[0][0]), 80'h0);
    @(negedge clk);
    we[0] = 2'b00; rtag[1][0] = 7'd31;
    #1;
    chk("R2 no pending for 31", rpend[1], 80'h0);
    chk("R2 local 31 zero", 80'(rdat[0][0]), 80'h0);
    @(negedge clk);
    #1;
    chk("R2 remote 31 zero", 80'(rdat[1][0]), 80'h0);
    done = 1;
  end

  initial begin
    wait (done);
    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule